// File: doc/BRIEF.md
# Interrupt Distributor Global Control Block

This block holds the small set of global words that sit at the bottom of an interrupt distributor's register space. Software reaches it through a simple 32-bit read/write request bus. There are four word slots. The first holds the master enable for the whole distributor. The second is a read-only capability word. The design computes it at elaboration time from the number of shared interrupt lines and the number of attached processors. The third is a fixed identification word that carries a product code and an implementer code. The fourth always reads as zero.

When software turns the master enable on, after it was off, the block raises a wake strobe towards every processor interface for exactly one clock cycle. That lets them re-evaluate any interrupts that are pending. Writes that keep the enable on, or that turn it off, produce no strobe. Read data is registered and comes back one cycle after the request, together with a valid flag.

Top module: `dist_gctl_top`

## Requirements
- R1: The word is chosen by `req_word` (byte address bits [3:2]): 0 is control, 1 is capability, 2 is identification, and 3 reads as all zeros.
- R2: After a synchronous reset, the master enable (control bit 0) reads 0 and no wake strobe is active.
- R3: A write to word 0 sets the master enable to `req_wdata[0]`. A read of word 0 returns the enable in bit 0, and bits [31:1] read as zero.
- R4: The capability word holds ((32 + SHARED_LINES) / 32) - 1 in bits [4:0] and CPU_COUNT - 1 in bits [7:5]. All other bits are zero. With the defaults (64 shared lines, 4 CPUs) it is 0x00000062.
- R5: The identification word holds PRODUCT_CODE in bits [31:24] and IMPL_CODE in bits [11:0]. All other bits are zero. With the defaults it is 0x4B00043B.
- R6: A write to word 0 that moves the enable from 0 to 1 sets every bit of `wake_cpu` high for exactly the one cycle after the write edge. A write that leaves the enable at 1, or that writes 0, raises no strobe.
- R7: Writes to words 1, 2 and 3 have no effect. The enable, all read values and `wake_cpu` are unchanged.
- R8: A read request presented at a clock edge drives `rd_valid` high, with the selected word on `rd_data`, in the following cycle. A write request leaves `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 2 | Word select (byte address bits [3:2]) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Registered read data |
| wake_cpu | output | CPU_COUNT | One-cycle wake strobe to each processor interface |

## Verification
The hardest case to reach is a 0-to-1 enable write that comes directly after writes that leave the enable alone: writes of 1 over 1, and writes that land on the read-only words. A strobe that is missing, or one that appears in the wrong place, is visible only in that single following cycle. The random stream therefore biases writes towards word 0 and towards a one in the enable bit. This makes repeated sets, clears and sets back-to-back common. Every transaction is checked against a bench model of the enable, and that check includes the strobe cycle itself. Directed sequences before the random stream cover reset, each read-only word, and a double set.

// File: rtl/dist_gctl_pkg.sv
package dist_gctl_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        WSEL_CTRL  = 2'd0,
        WSEL_CAPS  = 2'd1,
        WSEL_IDENT = 2'd2,
        WSEL_ZERO  = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        word_sel_e        sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] caps_word(input int shared_lines, input int cpus);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[4:0] = 5'(((32 + shared_lines) / 32) - 1);
        w[7:5] = 3'(cpus - 1);
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ident_word(input logic [7:0] product,
                                                      input logic [11:0] impl);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[31:24] = product;
        w[11:0]  = impl;
        return w;
    endfunction

endpackage

// File: rtl/dist_gctl_decode.sv
module dist_gctl_decode
    import dist_gctl_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_word,
    input  logic [DATA_W-1:0] req_wdata,
    output bus_req_t          req
);
    always_comb begin
        req.rd    = req_valid & ~req_write;
        req.wr    = req_valid & req_write;
        req.sel   = word_sel_e'(req_word);
        req.wdata = req_wdata;
    end
endmodule

// File: rtl/dist_gctl_enable.sv
module dist_gctl_enable
    import dist_gctl_pkg::*;
#(
    parameter int CPU_COUNT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_wr,
    input  logic                 ctrl_bit,
    output logic                 enable,
    output logic [CPU_COUNT-1:0] wake
);
    logic en_q;
    logic wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= ctrl_wr & ctrl_bit & ~en_q;
            if (ctrl_wr)
                en_q <= ctrl_bit;
        end
    end

    assign enable = en_q;

    for (genvar c = 0; c < CPU_COUNT; c++) begin : g_fan
        assign wake[c] = wake_q;
    end

    // R6: a strobe only follows a real off-to-on transition
    a_r6_wake_on_rise: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> (en_q && !$past(en_q)));
    // R6: a strobe never lasts two cycles
    a_r6_wake_single: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> !wake_q);
    // R2: enable is off in the first cycle out of reset
    a_r2_reset_off: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!en_q && !wake_q));
    // R7: without a control write the enable holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(en_q));
endmodule

// File: rtl/dist_gctl_rdmux.sv
module dist_gctl_rdmux
    import dist_gctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] CAPS  = '0,
    parameter logic [DATA_W-1:0] IDENT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  word_sel_e         sel,
    input  logic              enable,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_d;

    always_comb begin
        unique case (sel)
            WSEL_CTRL:  word_d = {{(DATA_W-1){1'b0}}, enable};
            WSEL_CAPS:  word_d = CAPS;
            WSEL_IDENT: word_d = IDENT;
            default:    word_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            if (rd)
                rd_data <= word_d;
        end
    end

    // R8: valid data follows exactly one read request
    a_r8_valid_timing: assert property (@(posedge clk) disable iff (rst)
        rd |=> rd_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rd_valid);
    // R1: the zero slot returns nothing
    a_r1_zero_slot: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == WSEL_ZERO) |=> (rd_data == '0));
    // R3: control reads carry only bit 0
    a_r3_ctrl_upper: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == WSEL_CTRL) |=> (rd_data[DATA_W-1:1] == '0));
endmodule

// File: rtl/dist_gctl_top.sv
module dist_gctl_top
    import dist_gctl_pkg::*;
#(
    parameter int          SHARED_LINES = 64,
    parameter int          CPU_COUNT    = 4,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_word,
    input  logic [31:0]          req_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [CPU_COUNT-1:0] wake_cpu
);
    localparam logic [DATA_W-1:0] CAPS_W  = caps_word(SHARED_LINES, CPU_COUNT);
    localparam logic [DATA_W-1:0] IDENT_W = ident_word(PRODUCT_CODE, IMPL_CODE);

    initial begin
        assert (CPU_COUNT >= 1 && CPU_COUNT <= 8);
        assert (SHARED_LINES % 32 == 0 && SHARED_LINES <= 988);
    end

    bus_req_t req;
    logic     enable;

    dist_gctl_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_wdata (req_wdata),
        .req       (req)
    );

    dist_gctl_enable #(.CPU_COUNT(CPU_COUNT)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (req.wr && req.sel == WSEL_CTRL),
        .ctrl_bit (req.wdata[0]),
        .enable   (enable),
        .wake     (wake_cpu)
    );

    dist_gctl_rdmux #(.CAPS(CAPS_W), .IDENT(IDENT_W)) u_rdmux (
        .clk      (clk),
        .rst      (rst),
        .rd       (req.rd),
        .sel      (req.sel),
        .enable   (enable),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/test_dist_gctl_top.sv
module test_dist_gctl_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 4;
    localparam int NSHARED    = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [1:0]      req_word = '0;
    logic [31:0]     req_wdata = '0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic [NCPU-1:0] wake_cpu;

    int n_vec  = 0;
    int n_fail = 0;
    bit en_m   = 1'b0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dist_gctl_top #(.SHARED_LINES(NSHARED), .CPU_COUNT(NCPU)) i_dist_gctl_top (
        .clk, .rst, .req_valid, .req_write, .req_word, .req_wdata,
        .rd_valid, .rd_data, .wake_cpu
    );

    function automatic logic [31:0] exp_word(input logic [1:0] w, input bit en);
        case (w)
            2'd0:    return {31'b0, en};
            2'd1:    return 32'(((32 + NSHARED) / 32) - 1) | 32'((NCPU - 1) << 5);
            2'd2:    return 32'h4B00043B;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one transaction; outputs sampled at the following negedge
    task automatic op(input bit wr, input logic [1:0] w, input logic [31:0] d);
        bit rise;
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = w; req_wdata = d;
        exp_rd = exp_word(w, en_m);
        rise = 1'b0;
        if (wr && w == 2'd0) begin
            rise = d[0] && !en_m;
            en_m = d[0];
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rise ? "R6 wake on rise" : "R6/R7 no wake", 32'(wake_cpu),
              rise ? 32'((1 << NCPU) - 1) : 32'h0);
        check("R8 rd_valid", 32'(rd_valid), 32'(!wr));
        if (!wr) begin
            case (w)
                2'd0: check("R3 ctrl read", rd_data, exp_rd);
                2'd1: check("R4 caps read", rd_data, exp_rd);
                2'd2: check("R5 ident read", rd_data, exp_rd);
                default: check("R1 zero slot", rd_data, exp_rd);
            endcase
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset wake", 32'(wake_cpu), 32'h0);
        check("R2 reset rd_valid", 32'(rd_valid), 32'h0);
        op(0, 2'd0, '0);                       // R2 enable reads 0
        op(0, 2'd1, '0);                       // R4 0x62
        op(0, 2'd2, '0);                       // R5
        op(0, 2'd3, '0);                       // R1
        op(1, 2'd1, 32'hFFFF_FFFF);            // R7 writes ignored
        op(1, 2'd2, 32'hFFFF_FFFF);
        op(1, 2'd3, 32'hFFFF_FFFF);
        op(0, 2'd0, '0);
        op(0, 2'd1, '0);
        op(0, 2'd2, '0);
        op(1, 2'd0, 32'hFFFF_FFFF);            // R6 rise, R3 upper bits dropped
        op(1, 2'd0, 32'h1);                    // R6 1->1 no wake
        op(0, 2'd0, '0);
        op(1, 2'd0, 32'h0);                    // R6 clear no wake
        op(1, 2'd0, 32'h1);                    // R6 rise again
        op(1, 2'd0, 32'hFFFF_FFFE);            // R3 bit0 only
        op(0, 2'd0, '0);
        void'($urandom(32'd4242));
        for (int i = 0; i < 400; i++) begin
            bit wr = ($urandom % 3) != 0;
            logic [1:0] w = ($urandom % 2) ? 2'd0 : 2'($urandom);
            logic [31:0] d = $urandom;
            if ($urandom % 2) d[0] = 1'b1;
            op(wr, w, d);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule